// File: doc/BRIEF.md
# Descriptor Table Register Unit

This unit holds the two system table registers of a processor core: a global table register and an interrupt table register. Each one holds a 16-bit limit and a 32-bit linear base. The unit runs the load and store forms of the two-byte `0F 01` system group. It receives the instruction already decoded into these fields:

- the ModR/M reg field and mod field;
- the operand size;
- the processor mode;
- the current privilege level;
- the effective address of the six-byte memory operand.

It moves the operand as three 16-bit memory accesses: limit first, then base bits 15:0, then base bits 31:16. Each access is a request on a valid/ready channel followed by a response on a valid/ready channel. The unit ends each instruction with a one-cycle `done` pulse or a one-cycle exception pulse carrying the vector number.

Back-pressure rules:

- **Instruction issue.** The unit raises `start_ready` only while idle. An instruction is accepted on a clock edge where `start_valid` and `start_ready` are both high.
- **Memory request.** Once `mreq_valid` rises, it stays high with address, direction and write data held until a clock edge sees `mreq_ready` high.
- **Memory response.** `mrsp_ready` is high only while a response is awaited. Only one access is ever outstanding.
- **Page faults.** A page fault is reported as `mrsp_err` on a response.

Top module: `desc_table_unit`

## Requirements
- R1: The reg field selects the operation: 0 stores the global register, 1 stores the interrupt register, 2 loads the global register, 3 loads the interrupt register. Reg values 4 to 7 raise vector 6 with no memory access.
- R2: A load reads three words, in this order, from addresses ea, ea+2 and ea+4. The first word becomes the limit and the next two become base bits 15:0 and 31:16. The register changes in one cycle, only after the third response succeeds.
- R3: With 16-bit operand size (`op32`=0), a load takes base bits 23:0 from the operand, ignores the top byte of the third word, and writes zero into base bits 31:24.
- R4: With 32-bit operand size (`op32`=1), a load takes all 32 base bits from the operand.
- R5: A store writes three words to ea, ea+2 and ea+4: the limit, base bits 15:0, then base bits 31:16. This holds for both operand sizes.
- R6: A load in protected mode (`cpu_mode` 1, and 3 is treated the same) with `cpl` not 0 raises vector 13 (general protection, error code 0). It makes no memory access and leaves both registers unchanged. Stores are allowed at any privilege level.
- R7: mod equal to 3 (a register operand) raises vector 6 in every mode, with no memory access. This check takes priority over every other fault.
- R8: In real mode (`cpu_mode` 0) and virtual-8086 mode (`cpu_mode` 2), an ea above 0FFFAh raises vector 13 with no memory access. In these modes `cpl` is not checked. Protected mode applies no range check.
- R9: Every accepted instruction produces exactly one of `done` or `exc_valid`.
  - A fault found at decode shows in the cycle right after the accepting edge.
  - `done` never comes earlier than 11 cycles after the accepting edge.
  - With memory that accepts and answers at once, `done` comes exactly 11 cycles after the accepting edge.
- R10: A response with `mrsp_err` high ends the instruction. The unit raises vector 14 and issues no further request. Both registers stay unchanged.
- R11: `start_ready` is low from acceptance until the instruction ends. A request that is not accepted keeps valid, address, direction and data stable.
- R12: After reset, both limits read 0FFFFh and both bases read 0, with `done` and `exc_valid` low and the unit idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Instruction offered |
| start_ready | output | 1 | Unit idle and able to accept |
| modrm_reg | input | 3 | Reg field of the ModR/M byte |
| modrm_mod | input | 2 | Mod field of the ModR/M byte |
| op32 | input | 1 | 1 = 32-bit operand size |
| cpu_mode | input | 2 | 0 real, 1 protected, 2 virtual-8086 |
| cpl | input | 2 | Current privilege level |
| ea | input | ADDR_W | Effective address of the operand |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request accepted |
| mreq_write | output | 1 | 1 = write, 0 = read |
| mreq_addr | output | ADDR_W | Word address (byte granular) |
| mreq_wdata | output | 16 | Write data |
| mrsp_valid | input | 1 | Memory response valid |
| mrsp_ready | output | 1 | Unit awaiting a response |
| mrsp_rdata | input | 16 | Read data |
| mrsp_err | input | 1 | Page fault on this access |
| done | output | 1 | Instruction finished without fault |
| exc_valid | output | 1 | Exception pulse |
| exc_vector | output | 8 | Exception vector (6, 13 or 14) |
| glob_limit | output | 16 | Global register limit |
| glob_base | output | 32 | Global register base |
| intr_limit | output | 16 | Interrupt register limit |
| intr_base | output | 32 | Interrupt register base |

## Verification
The assertions assume the memory side behaves as follows:

- It raises `mrsp_valid` only while a response is awaited.
- It holds `mrsp_valid` until the response is taken.
- It gives exactly one response per accepted request.

The assertions also assume the decode inputs stay stable for the cycle in which `start_valid` is high. The bench memory model keeps within these assumptions. It records each accepted request and answers it once, after a random delay, and drops `mrsp_valid` on the edge after the handshake. It randomizes only `mreq_ready` and the response delay. It changes the instruction fields only while the unit is idle.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam int LIM_W    = 16;
  localparam int BASE_W   = 32;
  localparam int NARROW_W = 24;
  localparam int WORD_W   = 16;
  localparam int NWORDS   = (LIM_W + BASE_W) / WORD_W;
  localparam int WBYTES   = WORD_W / 8;
  localparam int OPND_BYTES = NWORDS * WBYTES;
  localparam int REAL_LAST  = 'hFFFF - (OPND_BYTES - 1);

  localparam logic [1:0] MODE_REAL = 2'd0;
  localparam logic [1:0] MODE_PROT = 2'd1;
  localparam logic [1:0] MODE_V86  = 2'd2;

  localparam logic [7:0] VEC_UD = 8'd6;
  localparam logic [7:0] VEC_GP = 8'd13;
  localparam logic [7:0] VEC_PF = 8'd14;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [LIM_W-1:0]  limit;
  } tbl_reg_t;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP, S_HOLD} seq_st_e;
endpackage

// File: rtl/dtu_check.sv
module dtu_check
  import dtu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [2:0]        reg_i,
  input  logic [1:0]        mod_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        cpl_i,
  input  logic [ADDR_W-1:0] ea_i,
  output logic              fault_o,
  output logic [7:0]        vec_o,
  output logic              load_o,
  output logic              sel_o
);
  logic prot;

  assign prot   = (mode_i != MODE_REAL) && (mode_i != MODE_V86);
  assign load_o = reg_i[1];
  assign sel_o  = reg_i[0];

  // Priority: register operand / bad group member, privilege, real-mode range
  always_comb begin
    fault_o = 1'b0;
    vec_o   = VEC_UD;
    if (mod_i == 2'b11 || reg_i[2]) begin
      fault_o = 1'b1;
      vec_o   = VEC_UD;
    end else if (prot && load_o && cpl_i != 2'd0) begin
      fault_o = 1'b1;
      vec_o   = VEC_GP;
    end else if (!prot && ea_i > ADDR_W'(REAL_LAST)) begin
      fault_o = 1'b1;
      vec_o   = VEC_GP;
    end
  end
endmodule

// File: rtl/dtu_seq.sv
module dtu_seq
  import dtu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LOAD_LAT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic              fault_i,
  input  logic [7:0]        vec_i,
  input  logic              load_i,
  input  logic              sel_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  tbl_reg_t          cur_i,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic              mreq_write,
  output logic [ADDR_W-1:0] mreq_addr,
  output logic [WORD_W-1:0] mreq_wdata,
  input  logic              mrsp_valid,
  output logic              mrsp_ready,
  input  logic [WORD_W-1:0] mrsp_rdata,
  input  logic              mrsp_err,
  output logic              commit_o,
  output logic              csel_o,
  output logic              cwide_o,
  output tbl_reg_t          cval_o,
  output logic              done_o,
  output logic              exc_valid_o,
  output logic [7:0]        exc_vector_o
);
  localparam int CNT_W = $clog2(LOAD_LAT + 1);
  localparam int IDX_W = $clog2(NWORDS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

  seq_st_e                   st;
  logic [IDX_W-1:0]          idx;
  logic [CNT_W-1:0]          cnt;
  logic                      ld_q, sel_q, wide_q;
  logic [ADDR_W-1:0]         ea_q;
  logic [WORD_W*NWORDS-1:0]  opnd_q;
  logic                      lat_met;

  assign start_ready = (st == S_IDLE);
  assign mreq_valid  = (st == S_REQ);
  assign mrsp_ready  = (st == S_RSP);
  assign mreq_write  = !ld_q;
  assign mreq_addr   = ea_q + ADDR_W'(idx) * ADDR_W'(WBYTES);
  assign mreq_wdata  = opnd_q[int'(idx)*WORD_W +: WORD_W];
  assign lat_met     = (cnt >= CNT_W'(LOAD_LAT));

  assign commit_o    = (st == S_HOLD) && lat_met && ld_q;
  assign csel_o      = sel_q;
  assign cwide_o     = wide_q;
  assign cval_o.limit = opnd_q[LIM_W-1:0];
  assign cval_o.base  = wide_q ? opnd_q[LIM_W +: BASE_W]
                               : {{(BASE_W-NARROW_W){1'b0}}, opnd_q[LIM_W +: NARROW_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  idx <= '0;  cnt <= '0;
      ld_q <= 1'b0;  sel_q <= 1'b0;  wide_q <= 1'b0;
      ea_q <= '0;    opnd_q <= '0;
      done_o <= 1'b0;  exc_valid_o <= 1'b0;  exc_vector_o <= '0;
    end else begin
      done_o      <= 1'b0;
      exc_valid_o <= 1'b0;
      if (st != S_IDLE && cnt != '1) cnt <= cnt + 1'b1;
      case (st)
        S_IDLE: if (start_valid) begin
          if (fault_i) begin
            exc_valid_o  <= 1'b1;
            exc_vector_o <= vec_i;
          end else begin
            st <= S_REQ;  idx <= '0;  cnt <= CNT_W'(1);
            ld_q <= load_i;  sel_q <= sel_i;  wide_q <= wide_i;
            ea_q <= ea_i;    opnd_q <= cur_i;
          end
        end
        S_REQ: if (mreq_ready) st <= S_RSP;
        S_RSP: if (mrsp_valid) begin
          if (mrsp_err) begin
            exc_valid_o  <= 1'b1;
            exc_vector_o <= VEC_PF;
            st <= S_IDLE;
          end else begin
            if (ld_q) opnd_q[int'(idx)*WORD_W +: WORD_W] <= mrsp_rdata;
            if (idx == LAST) st <= S_HOLD;
            else begin
              idx <= idx + 1'b1;
              st  <= S_REQ;
            end
          end
        end
        S_HOLD: if (lat_met) begin
          done_o <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_addr)
                                 && $stable(mreq_write) && $stable(mreq_wdata));

  assert_pf_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mrsp_valid && mrsp_ready && mrsp_err |=> exc_valid_o && exc_vector_o == VEC_PF
                                            && !mreq_valid && !done_o);

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && exc_valid_o));

  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && start_ready && !fault_i |=> !start_ready);
endmodule

// File: rtl/dtu_regs.sv
module dtu_regs
  import dtu_pkg::*;
#(
  parameter int NTBL = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     commit_i,
  input  logic     sel_i,
  input  tbl_reg_t val_i,
  output tbl_reg_t glob_o,
  output tbl_reg_t intr_o
);
  tbl_reg_t tbl_q [NTBL];

  for (genvar i = 0; i < NTBL; i++) begin : g_tbl
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tbl_q[i].limit <= '1;
        tbl_q[i].base  <= '0;
      end else if (commit_i && (32'(sel_i) == i)) begin
        tbl_q[i] <= val_i;
      end
    end
  end

  assign glob_o = tbl_q[0];
  assign intr_o = tbl_q[1];

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(tbl_q[0]) && $stable(tbl_q[1]));
endmodule

// File: rtl/desc_table_unit.sv
module desc_table_unit
  import dtu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LOAD_LAT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [2:0]        modrm_reg,
  input  logic [1:0]        modrm_mod,
  input  logic              op32,
  input  logic [1:0]        cpu_mode,
  input  logic [1:0]        cpl,
  input  logic [ADDR_W-1:0] ea,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic              mreq_write,
  output logic [ADDR_W-1:0] mreq_addr,
  output logic [15:0]       mreq_wdata,
  input  logic              mrsp_valid,
  output logic              mrsp_ready,
  input  logic [15:0]       mrsp_rdata,
  input  logic              mrsp_err,
  output logic              done,
  output logic              exc_valid,
  output logic [7:0]        exc_vector,
  output logic [15:0]       glob_limit,
  output logic [31:0]       glob_base,
  output logic [15:0]       intr_limit,
  output logic [31:0]       intr_base
);
  logic       chk_fault, chk_load, chk_sel;
  logic [7:0] chk_vec;
  logic       commit, csel, cwide;
  tbl_reg_t   glob_q, intr_q, cur, cval;

  dtu_check #(.ADDR_W(ADDR_W)) u_check (
    .reg_i(modrm_reg), .mod_i(modrm_mod), .mode_i(cpu_mode), .cpl_i(cpl),
    .ea_i(ea), .fault_o(chk_fault), .vec_o(chk_vec), .load_o(chk_load),
    .sel_o(chk_sel)
  );

  assign cur = chk_sel ? intr_q : glob_q;

  dtu_seq #(.ADDR_W(ADDR_W), .LOAD_LAT(LOAD_LAT)) u_seq (
    .clk, .rst_n, .start_valid, .start_ready,
    .fault_i(chk_fault), .vec_i(chk_vec), .load_i(chk_load), .sel_i(chk_sel),
    .wide_i(op32), .ea_i(ea), .cur_i(cur),
    .mreq_valid, .mreq_ready, .mreq_write, .mreq_addr, .mreq_wdata,
    .mrsp_valid, .mrsp_ready, .mrsp_rdata, .mrsp_err,
    .commit_o(commit), .csel_o(csel), .cwide_o(cwide), .cval_o(cval),
    .done_o(done), .exc_valid_o(exc_valid), .exc_vector_o(exc_vector)
  );

  dtu_regs #(.NTBL(2)) u_regs (
    .clk, .rst_n, .commit_i(commit), .sel_i(csel), .val_i(cval),
    .glob_o(glob_q), .intr_o(intr_q)
  );

  assign glob_limit = glob_q.limit;
  assign glob_base  = glob_q.base;
  assign intr_limit = intr_q.limit;
  assign intr_base  = intr_q.base;

  assert_narrow_glob_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !cwide && !csel |=> glob_q.base[BASE_W-1:NARROW_W] == '0);

  assert_narrow_intr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !cwide && csel |=> intr_q.base[BASE_W-1:NARROW_W] == '0);
endmodule

// File: tb/desc_table_unit_tb.sv
`timescale 1ns/1ps
module desc_table_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0, start_ready;
  logic [2:0] modrm_reg = '0;
  logic [1:0] modrm_mod = '0, cpu_mode = '0, cpl = '0;
  logic op32 = 1'b0;
  logic [31:0] ea = '0;
  logic mreq_valid, mreq_write, mrsp_ready;
  logic mreq_ready = 1'b1;
  logic [31:0] mreq_addr;
  logic [15:0] mreq_wdata;
  logic mrsp_valid = 1'b0, mrsp_err = 1'b0;
  logic [15:0] mrsp_rdata = '0;
  logic done, exc_valid;
  logic [7:0] exc_vector;
  logic [15:0] glob_limit, intr_limit;
  logic [31:0] glob_base, intr_base;

  always #5 clk = ~clk;

  desc_table_unit u_dut (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // memory model state
  int acc_n = 0, err_at = 3;
  bit rnd_mem = 0;
  logic [15:0] salt = '0;
  logic [31:0] log_addr [8];
  logic        log_wr   [8];
  logic [15:0] log_wd   [8];
  bit req_seen = 0, rsp_taken = 0, pend = 0, pend_err = 0;
  int wait_n = 0;
  logic [31:0] pend_addr;
  bit hold_chk = 0;
  logic [31:0] hold_addr;
  logic [15:0] hold_wd;

  logic [15:0] m_lim [2];
  logic [31:0] m_base [2];

  function automatic logic [15:0] mem_word(input logic [31:0] a);
    return (a[15:0] * 16'h9E37) ^ a[31:16] ^ salt;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    rsp_taken = mrsp_valid && mrsp_ready;
    if (hold_chk) begin
      chk(mreq_valid && mreq_addr == hold_addr && mreq_wdata == hold_wd,
          "R11 request not held", {32'(mreq_valid), mreq_addr}, {32'd1, hold_addr});
      hold_chk = 0;
    end
    if (mreq_valid && !mreq_ready) begin
      hold_chk = 1; hold_addr = mreq_addr; hold_wd = mreq_wdata;
    end
    if (mreq_valid && mreq_ready) begin
      if (acc_n < 8) begin
        log_addr[acc_n] = mreq_addr; log_wr[acc_n] = mreq_write; log_wd[acc_n] = mreq_wdata;
      end
      req_seen = 1; pend_addr = mreq_addr; pend_err = (acc_n == err_at);
      acc_n++;
    end
  end

  always @(negedge clk) begin
    if (rsp_taken) begin mrsp_valid = 0; mrsp_err = 0; rsp_taken = 0; end
    if (req_seen) begin pend = 1; wait_n = rnd_mem ? int'($urandom % 3) : 0; req_seen = 0; end
    if (pend && !mrsp_valid) begin
      if (wait_n == 0) begin
        mrsp_valid = 1; mrsp_rdata = mem_word(pend_addr); mrsp_err = pend_err; pend = 0;
      end else wait_n--;
    end
    mreq_ready = rnd_mem ? 1'($urandom % 2) : 1'b1;
  end

  task automatic run(input logic [2:0] rg, input logic [1:0] md, input bit w,
                     input logic [1:0] mo, input logic [1:0] pl, input logic [31:0] a,
                     input int e_at, input bit zero_wait);
    logic [7:0] ev;
    string tag;
    int k;
    bit got;
    bit prot;
    logic [15:0] w0, w1, w2;
    int sel;
    prot = (mo != 2'd0) && (mo != 2'd2);
    ev = 0; tag = "R2";
    if (md == 2'd3)                            begin ev = 6;  tag = "R7"; end
    else if (rg > 3)                           begin ev = 6;  tag = "R1"; end
    else if (prot && rg >= 2 && pl != 0)       begin ev = 13; tag = "R6"; end
    else if (!prot && a > 32'h0000_FFFA)       begin ev = 13; tag = "R8"; end
    salt = 16'($urandom);
    @(negedge clk);
    acc_n = 0; err_at = e_at;
    modrm_reg = rg; modrm_mod = md; op32 = w; cpu_mode = mo; cpl = pl; ea = a;
    start_valid = 1;
    @(posedge clk); #1;
    start_valid = 0;
    if (ev == 0) chk(!start_ready, "R11 ready while busy", 64'(start_ready), 64'd0);
    k = 0; got = 0;
    while (!got && k < 400) begin
      if (done || exc_valid) got = 1;
      else begin @(posedge clk); #1; k++; end
    end
    sel = int'(rg[0]);
    if (ev != 0) begin
      chk(exc_valid && !done && exc_vector == ev, tag, {56'(exc_valid), exc_vector}, {56'd1, ev});
      chk(k == 0, "R9 fault timing", 64'(k), 64'd0);
      chk(acc_n == 0, tag, 64'(acc_n), 64'd0);
    end else begin
      chk(acc_n == (e_at < 3 ? e_at + 1 : 3), "R2 access count", 64'(acc_n), 64'(e_at < 3 ? e_at + 1 : 3));
      for (int i = 0; i < acc_n && i < 3; i++)
        chk(log_addr[i] == a + 32'(2*i) && log_wr[i] == (rg < 2), rg < 2 ? "R5 addr" : "R2 addr",
            {31'd0, log_wr[i], log_addr[i]}, {31'd0, rg < 2, a + 32'(2*i)});
      if (e_at < 3) begin
        chk(exc_valid && !done && exc_vector == 8'd14, "R10 page fault", 64'(exc_vector), 64'd14);
        tag = "R10";
      end else begin
        chk(done && !exc_valid, "R9 done", {32'(done), 32'(exc_valid)}, {32'd1, 32'd0});
        chk(k >= 11, "R9 min latency", 64'(k), 64'd11);
        if (zero_wait) chk(k == 11, "R9 latency", 64'(k), 64'd11);
        if (rg >= 2) begin
          w0 = mem_word(a); w1 = mem_word(a + 2); w2 = mem_word(a + 4);
          m_lim[sel]  = w0;
          m_base[sel] = w ? {w2, w1} : {8'h00, w2[7:0], w1};
          tag = w ? "R4" : "R3";
        end else begin
          chk(log_wd[0] == m_lim[sel] && log_wd[1] == m_base[sel][15:0] && log_wd[2] == m_base[sel][31:16],
              "R5 store data", {16'd0, log_wd[2], log_wd[1], log_wd[0]}, {16'd0, m_base[sel], m_lim[sel]});
          tag = "R5";
        end
      end
    end
    chk(glob_limit == m_lim[0] && glob_base == m_base[0], tag, {glob_limit, glob_base}, {m_lim[0], m_base[0]});
    chk(intr_limit == m_lim[1] && intr_base == m_base[1], tag, {intr_limit, intr_base}, {m_lim[1], m_base[1]});
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_lim[0] = 16'hFFFF; m_lim[1] = 16'hFFFF; m_base[0] = 0; m_base[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    // R12 reset state
    chk(glob_limit == 16'hFFFF && glob_base == 0, "R12 glob reset", {glob_limit, glob_base}, {16'hFFFF, 32'd0});
    chk(intr_limit == 16'hFFFF && intr_base == 0, "R12 intr reset", {intr_limit, intr_base}, {16'hFFFF, 32'd0});
    chk(!done && !exc_valid && start_ready, "R12 idle", {done, exc_valid, start_ready}, 64'b001);

    run(3'd2, 2'd0, 1'b1, 2'd0, 2'd0, 32'h0000_1000, 3, 1);   // R4 global, real mode
    run(3'd3, 2'd0, 1'b0, 2'd1, 2'd0, 32'h00AB_CDE0, 3, 1);   // R3 interrupt, narrow
    run(3'd3, 2'd1, 1'b1, 2'd2, 2'd3, 32'h0000_2222, 3, 1);   // R8 v86 ignores cpl
    run(3'd0, 2'd0, 1'b1, 2'd1, 2'd3, 32'h0040_0000, 3, 1);   // R6 store allowed at cpl 3
    chk(done, "R6 store at cpl 3", 64'(done), 64'd1);
    run(3'd1, 2'd2, 1'b0, 2'd0, 2'd0, 32'h0000_0100, 3, 1);   // R5 narrow store keeps top byte
    run(3'd2, 2'd0, 1'b1, 2'd1, 2'd3, 32'h0000_3000, 3, 1);   // R6 privilege fault
    run(3'd3, 2'd3, 1'b1, 2'd1, 2'd0, 32'h0000_3000, 3, 1);   // R7 protected
    run(3'd2, 2'd3, 1'b0, 2'd0, 2'd3, 32'h0000_3000, 3, 1);   // R7 real
    run(3'd5, 2'd0, 1'b1, 2'd1, 2'd0, 32'h0000_3000, 3, 1);   // R1 bad reg
    run(3'd2, 2'd0, 1'b1, 2'd0, 2'd0, 32'h0000_FFFB, 3, 1);   // R8 over
    run(3'd2, 2'd0, 1'b1, 2'd2, 2'd0, 32'h0000_FFFA, 3, 1);   // R8 edge ok
    run(3'd3, 2'd0, 1'b1, 2'd1, 2'd0, 32'h1234_5678, 3, 1);   // R8 protected no range
    run(3'd2, 2'd0, 1'b1, 2'd1, 2'd0, 32'h0000_5000, 1, 1);   // R10 fault mid-load
    run(3'd3, 2'd0, 1'b0, 2'd0, 2'd0, 32'h0000_6000, 2, 1);   // R10 fault last word

    rnd_mem = 1;
    for (int t = 0; t < 120; t++) begin
      logic [2:0] rg;
      logic [1:0] md, mo, pl;
      logic [31:0] a;
      int e;
      rg = ($urandom % 8 == 0) ? 3'(4 + $urandom % 4) : 3'($urandom % 4);
      md = ($urandom % 6 == 0) ? 2'd3 : 2'($urandom % 3);
      mo = 2'($urandom % 3);
      pl = ($urandom % 2) ? 2'd0 : 2'($urandom % 4);
      if (mo == 2'd1) a = $urandom;
      else a = ($urandom % 4 == 0) ? 32'h0000_FFF0 + ($urandom % 16) : ($urandom & 32'h0000_FFFF);
      e = ($urandom % 8 == 0) ? int'($urandom % 3) : 3;
      run(rg, md, 1'($urandom % 2), mo, pl, a, e, 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule